// File: doc/BRIEF.md
# Register Transfer and Exchange Unit

This unit moves a value from one CPU register to another, or swaps the contents of two registers. The register set mixes 8-bit registers (A, B, CCR) with 16-bit ones (temp, D, X, Y, SP). A single control byte, the postbyte, selects the two registers and the operation. The unit sits between an external register file and the instruction sequencer. It reads both named registers through two read ports, widens or trims each value to suit its destination, and presents one or two writes to the register file.

An operation takes two clock cycles. In the start cycle the read indices come straight from the postbyte, and the read data is captured at the clock edge that ends the cycle. In the following cycle the write ports are enabled and done is high. Exchange and transfer widen 8-bit values differently. A transfer sign-extends an 8-bit source. An exchange forces all ones into the upper byte of a value that comes from B or CCR.

Top module: `xfer_exch_unit`

## Requirements
- R1: The first register index is postbyte bits 6:4 and the second is bits 2:0. The encoding is 0=A, 1=B, 2=CCR, 3=temp, 4=D, 5=X, 6=Y, 7=SP. During the start cycle, rd0_idx shows the first index and rd1_idx shows the second.
- R2: With postbyte bit 7 clear the operation is a transfer. Write port 0 writes the first register's value to the second index, and write port 1 stays disabled.
- R3: In a transfer from index 0, 1 or 2, the upper byte becomes 0xFF when the source's bit 7 is set and 0x00 otherwise. A source at index 3 to 7 passes through unchanged.
- R4: With postbyte bit 7 set the operation is an exchange. Port 0 writes the first register's value to the second index. Port 1 writes the second register's value to the first index. Both values are those read in the start cycle.
- R5: In an exchange, a value read from second index 1 or 2 gets upper byte 0xFF, whatever its bit 7. A value from second index 0, and any 8-bit value moving first-to-second, is zero-extended.
- R6: For source indices 0 to 2, only bits 7:0 of the read data are used. The upper read bits have no effect on any write.
- R7: Write data for destination index 0, 1 or 2 carries zeros in bits 15:8. Any other destination, D (index 4) included, receives all 16 bits.
- R8: Index 3 is passed through as a 16-bit register in both roles, with no widening or trimming. Which physical temporary it selects on read or on write is left to the register file.
- R9: done and the write enables are high exactly in the cycle after a start cycle is accepted, for one cycle. The postbyte and read data are sampled only in the start cycle.
- R10: A start raised in the same cycle as done is ignored and produces no further done.
- R11: After reset, done, wr0_en and wr1_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation this cycle |
| postbyte | input | 8 | Operation and register selection |
| rd0_idx | output | 3 | Read port 0 index (first register) |
| rd0_data | input | 16 | Read port 0 data |
| rd1_idx | output | 3 | Read port 1 index (second register) |
| rd1_data | input | 16 | Read port 1 data |
| wr0_en | output | 1 | Write port 0 enable |
| wr0_idx | output | 3 | Write port 0 index |
| wr0_data | output | 16 | Write port 0 data |
| wr1_en | output | 1 | Write port 1 enable (exchange only) |
| wr1_idx | output | 3 | Write port 1 index |
| wr1_data | output | 16 | Write port 1 data |
| done | output | 1 | Operation completes this cycle |

## Verification
The hardest case to reach is an exchange whose value from B or CCR has bit 7 clear yet still gets the 0xFF upper byte, and it has to land in a 16-bit destination for that byte to be visible. A second hard case is the proof that the garbage upper bits on 8-bit read data never leak into a write. The stimulus sweeps all 256 postbytes over four register-value sets. In those sets the 8-bit registers carry alternating bit-7 polarity and nonzero upper bits, so every pairing of source width, destination width and operation occurs with both sign states. A separate sequence holds start high into the done cycle and changes the postbyte during the write cycle, to show that neither affects the outputs.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 16;
  localparam int BYTE_W = DATA_W / 2;
  localparam int PB_W   = 8;
  localparam int OP_BIT = PB_W - 1;

  typedef enum logic [IDX_W-1:0] {
    RI_A   = 3'd0,
    RI_B   = 3'd1,
    RI_CC  = 3'd2,
    RI_TMP = 3'd3,
    RI_D   = 3'd4,
    RI_X   = 3'd5,
    RI_Y   = 3'd6,
    RI_SP  = 3'd7
  } reg_idx_e;

  function automatic logic is_narrow(input logic [IDX_W-1:0] idx);
    return idx < RI_TMP;
  endfunction

  // first-to-second value: sign-extend 8-bit sources only when sext is set
  function automatic logic [DATA_W-1:0] widen_fwd(input logic [IDX_W-1:0] idx,
                                                  input logic [DATA_W-1:0] raw,
                                                  input logic sext);
    logic [BYTE_W-1:0] lo;
    lo = raw[BYTE_W-1:0];
    if (is_narrow(idx))
      return {{BYTE_W{sext & lo[BYTE_W-1]}}, lo};
    return raw;
  endfunction

  // second-to-first value during exchange: B and CCR get an all-ones upper byte
  function automatic logic [DATA_W-1:0] widen_back(input logic [IDX_W-1:0] idx,
                                                   input logic [DATA_W-1:0] raw);
    logic [BYTE_W-1:0] lo;
    lo = raw[BYTE_W-1:0];
    if (idx == RI_B || idx == RI_CC)
      return {{BYTE_W{1'b1}}, lo};
    if (is_narrow(idx))
      return {{BYTE_W{1'b0}}, lo};
    return raw;
  endfunction

  function automatic logic [DATA_W-1:0] fit_dest(input logic [IDX_W-1:0] idx,
                                                 input logic [DATA_W-1:0] val);
    if (is_narrow(idx))
      return {{BYTE_W{1'b0}}, val[BYTE_W-1:0]};
    return val;
  endfunction
endpackage

// File: rtl/xfer_capture.sv
module xfer_capture
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PB_W-1:0]   postbyte,
  input  logic [DATA_W-1:0] rd0_data,
  input  logic [DATA_W-1:0] rd1_data,
  output logic              accept,
  output logic              busy_q,
  output logic [PB_W-1:0]   pb_q,
  output logic [DATA_W-1:0] v_first_q,
  output logic [DATA_W-1:0] v_second_q
);
  assign accept = start & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      pb_q       <= '0;
      v_first_q  <= '0;
      v_second_q <= '0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        pb_q       <= postbyte;
        v_first_q  <= rd0_data;
        v_second_q <= rd1_data;
      end
    end
  end
endmodule

// File: rtl/xfer_route.sv
module xfer_route
  import xfer_pkg::*;
(
  input  logic [PB_W-1:0]   pb,
  input  logic [DATA_W-1:0] v_first,
  input  logic [DATA_W-1:0] v_second,
  output logic              xchg,
  output logic [IDX_W-1:0]  w0_idx,
  output logic [DATA_W-1:0] w0_data,
  output logic [IDX_W-1:0]  w1_idx,
  output logic [DATA_W-1:0] w1_data
);
  logic [IDX_W-1:0]  first_idx;
  logic [IDX_W-1:0]  second_idx;
  logic [DATA_W-1:0] fwd_val;
  logic [DATA_W-1:0] back_val;

  always_comb begin
    xchg       = pb[OP_BIT];
    first_idx  = pb[2*IDX_W:IDX_W+1];
    second_idx = pb[IDX_W-1:0];
    fwd_val    = widen_fwd(first_idx, v_first, ~xchg);
    back_val   = widen_back(second_idx, v_second);
    w0_idx     = second_idx;
    w0_data    = fit_dest(second_idx, fwd_val);
    w1_idx     = first_idx;
    w1_data    = fit_dest(first_idx, back_val);
  end
endmodule

// File: rtl/xfer_exch_unit.sv
module xfer_exch_unit
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PB_W-1:0]   postbyte,
  output logic [IDX_W-1:0]  rd0_idx,
  input  logic [DATA_W-1:0] rd0_data,
  output logic [IDX_W-1:0]  rd1_idx,
  input  logic [DATA_W-1:0] rd1_data,
  output logic              wr0_en,
  output logic [IDX_W-1:0]  wr0_idx,
  output logic [DATA_W-1:0] wr0_data,
  output logic              wr1_en,
  output logic [IDX_W-1:0]  wr1_idx,
  output logic [DATA_W-1:0] wr1_data,
  output logic              done
);
  logic              accept;
  logic              busy_q;
  logic [PB_W-1:0]   pb_q;
  logic [DATA_W-1:0] v_first_q;
  logic [DATA_W-1:0] v_second_q;
  logic              xchg;

  assign rd0_idx = postbyte[2*IDX_W:IDX_W+1];
  assign rd1_idx = postbyte[IDX_W-1:0];

  xfer_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .postbyte   (postbyte),
    .rd0_data   (rd0_data),
    .rd1_data   (rd1_data),
    .accept     (accept),
    .busy_q     (busy_q),
    .pb_q       (pb_q),
    .v_first_q  (v_first_q),
    .v_second_q (v_second_q)
  );

  xfer_route u_route (
    .pb       (pb_q),
    .v_first  (v_first_q),
    .v_second (v_second_q),
    .xchg     (xchg),
    .w0_idx   (wr0_idx),
    .w0_data  (wr0_data),
    .w1_idx   (wr1_idx),
    .w1_data  (wr1_data)
  );

  assign done   = busy_q;
  assign wr0_en = busy_q;
  assign wr1_en = busy_q & xchg;
endmodule

// File: rtl/xfer_exch_chk.sv
module xfer_exch_chk
  import xfer_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [PB_W-1:0]   postbyte,
  input logic [DATA_W-1:0] rd0_data,
  input logic              wr0_en,
  input logic [IDX_W-1:0]  wr0_idx,
  input logic [DATA_W-1:0] wr0_data,
  input logic              wr1_en,
  input logic [IDX_W-1:0]  wr1_idx,
  input logic [DATA_W-1:0] wr1_data,
  input logic              done
);
  a_r9_start_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !done) |=> done);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_idle_no_writes: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!wr0_en && !wr1_en));

  a_r2_transfer_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(postbyte[OP_BIT])) |-> (wr0_en && !wr1_en &&
      wr0_idx == $past(postbyte[IDX_W-1:0])));

  a_r4_exchange_targets: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(postbyte[OP_BIT])) |-> (wr0_en && wr1_en &&
      wr1_idx == $past(postbyte[2*IDX_W:IDX_W+1]) &&
      wr0_idx == $past(postbyte[IDX_W-1:0])));

  a_r3_wide_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(postbyte[OP_BIT]) && wr0_idx >= 3'd3 &&
     $past(postbyte[2*IDX_W:IDX_W+1]) >= 3'd3) |-> (wr0_data == $past(rd0_data)));

  a_r5_back_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1_en && (wr0_idx == 3'd1 || wr0_idx == 3'd2) && wr1_idx >= 3'd3)
      |-> (wr1_data[DATA_W-1:BYTE_W] == {BYTE_W{1'b1}}));

  a_r7_narrow_dest0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en && wr0_idx < 3'd3) |-> (wr0_data[DATA_W-1:BYTE_W] == '0));

  a_r7_narrow_dest1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr1_en && wr1_idx < 3'd3) |-> (wr1_data[DATA_W-1:BYTE_W] == '0));
endmodule

bind xfer_exch_unit xfer_exch_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .postbyte (postbyte),
  .rd0_data (rd0_data),
  .wr0_en   (wr0_en),
  .wr0_idx  (wr0_idx),
  .wr0_data (wr0_data),
  .wr1_en   (wr1_en),
  .wr1_idx  (wr1_idx),
  .wr1_data (wr1_data),
  .done     (done)
);

// File: tb/tb_xfer_exch_unit.sv
`timescale 1ns/1ps
module tb_xfer_exch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  postbyte = 8'h00;
  logic [2:0]  rd0_idx, rd1_idx, wr0_idx, wr1_idx;
  logic [15:0] rd0_data, rd1_data, wr0_data, wr1_data;
  logic        wr0_en, wr1_en, done;
  logic [15:0] vals [8];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign rd0_data = vals[rd0_idx];
  assign rd1_data = vals[rd1_idx];

  xfer_exch_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .postbyte(postbyte),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_set(input int k);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] base;
      base = 16'h1357 * (i + 1) + 16'h4C2B * k + 16'h0100;
      if (i < 3) vals[i] = {base[15:8] | 8'h01, (k[0] ^ i[0] ^ k[1]), base[6:0]};
      else       vals[i] = base;
    end
  endtask

  // expected data, written arithmetically
  function automatic logic [15:0] exp_fwd(input int f, input int s, input bit x);
    int v;
    v = vals[f];
    if (f <= 2) begin
      v = v % 256;
      if (!x && v >= 128) v = v + 65280;
    end
    if (s <= 2) v = v % 256;
    return 16'(v);
  endfunction

  function automatic logic [15:0] exp_back(input int f, input int s);
    int v;
    v = vals[s];
    if (s <= 2) v = v % 256;
    if (s == 1 || s == 2) v = v + 65280;
    if (f <= 2) v = v % 256;
    return 16'(v);
  endfunction

  task automatic run_op(input logic [7:0] p);
    int f, s;
    bit x;
    f = int'(p[6:4]); s = int'(p[2:0]); x = p[7];
    @(negedge clk);
    chk(done == 1'b0, "R9 idle before start", {15'b0, done}, 16'h0);
    start = 1'b1; postbyte = p;
    #0.5;
    chk(rd0_idx == p[6:4], "R1 rd0_idx", {13'b0, rd0_idx}, {13'b0, p[6:4]});
    chk(rd1_idx == p[2:0], "R1 rd1_idx", {13'b0, rd1_idx}, {13'b0, p[2:0]});
    @(negedge clk);
    start = 1'b0; postbyte = ~p;
    #0.5;
    chk(done == 1'b1, "R9 done", {15'b0, done}, 16'h1);
    chk(wr0_en == 1'b1, "R2 wr0_en", {15'b0, wr0_en}, 16'h1);
    chk(wr0_idx == p[2:0], "R2 wr0_idx", {13'b0, wr0_idx}, {13'b0, p[2:0]});
    chk(wr0_data == exp_fwd(f, s, x), x ? "R5 fwd data" : "R3 transfer data",
        wr0_data, exp_fwd(f, s, x));
    chk(wr1_en == x, x ? "R4 wr1_en" : "R2 wr1_en off", {15'b0, wr1_en}, {15'b0, x});
    if (x) begin
      chk(wr1_idx == p[6:4], "R4 wr1_idx", {13'b0, wr1_idx}, {13'b0, p[6:4]});
      chk(wr1_data == exp_back(f, s), "R5 back data", wr1_data, exp_back(f, s));
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) vals[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R11 done reset", {15'b0, done}, 16'h0);
    chk(wr0_en == 1'b0 && wr1_en == 1'b0, "R11 wr_en reset", {14'b0, wr1_en, wr0_en}, 16'h0);
    rst_n = 1'b1;

    for (int k = 0; k < 4; k++) begin
      load_set(k);
      for (int p = 0; p < 256; p++) run_op(8'(p));
    end

    // R6: upper bits of 8-bit reads must not leak
    load_set(1);
    vals[1] = 16'h7F05;
    run_op(8'h15);
    chk(wr0_data == 16'h0005, "R6 narrow read upper ignored", wr0_data, 16'h0005);
    // R8: temp index passes 16 bits in both directions
    vals[3] = 16'h9ABC; vals[6] = 16'h1234;
    run_op(8'hB6);
    chk(wr0_data == 16'h9ABC && wr1_data == 16'h1234, "R8 temp exchange",
        wr0_data, 16'h9ABC);
    // R7: D destination gets 16 bits from sign-extended A
    vals[0] = 16'h3380;
    run_op(8'h04);
    chk(wr0_data == 16'hFF80, "R7 D dest full width", wr0_data, 16'hFF80);

    // R10: start held into the done cycle
    load_set(2);
    @(negedge clk);
    start = 1'b1; postbyte = 8'h45;
    @(negedge clk);
    postbyte = 8'hC7;
    #0.5;
    chk(done == 1'b1 && wr1_en == 1'b0, "R10 first op done", {14'b0, wr1_en, done}, 16'h1);
    chk(wr0_idx == 3'd5, "R10 first op idx", {13'b0, wr0_idx}, 16'h5);
    @(negedge clk);
    start = 1'b0;
    #0.5;
    chk(done == 1'b0, "R10 start during done ignored", {15'b0, done}, 16'h0);
    @(negedge clk);
    chk(done == 1'b0, "R10 no late done", {15'b0, done}, 16'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R9 watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule